// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of a small processor core that carries out the hardware side of taking an interrupt and of coming back from one. It owns the program counter, the status word and the stack pointer. While the core executes normally, the core updates these through a load port. When an interrupt request is pending, global enable is set and the current instruction has completed, the block takes over. It saves the return address and the status word on a downward-growing stack in word memory. It then acknowledges the request, zeroes the status word, fetches the handler address from the vector table and places it in the program counter. The whole sequence takes six cycles.

A return command from the decoder, given at an instruction boundary, runs the reverse sequence. The status word is popped first and the program counter second. The enable and low-power settings that were in force before the interrupt therefore come back. The block also produces the core clock-run signal. The clock stops whenever the status word selects a low-power mode and no sequence is running. A request that arrives while the core sleeps restarts the clock in the first entry cycle, and a return that restores a low-power mode stops the clock again.

Top module: `irq_seq_core`

## Requirements
- R1: After reset, busy is 0, clk_run is 1, the status word is 0, and the program counter and stack pointer hold their reset parameters (0x0100 and 0x0080 by default).
- R2: A request is accepted only while idle, with status bit 3 (global enable) set, and either at an instruction boundary or while the clock is stopped. A request that is held without a boundary, or held while global enable is 0, leaves busy at 0.
- R3: Entry writes the program counter to address SP-2 and then the status word to address SP-4, in two consecutive cycles. SP ends 4 lower.
- R4: irq_ack is a single-cycle pulse in the fourth entry cycle, when the vector address is sampled. From the next cycle on, the status word reads 0.
- R5: Entry keeps busy high for exactly 6 cycles. Afterwards the program counter holds the memory word found at the sampled vector address.
- R6: While idle, a nonzero low-power field (status bits 7:4) drives clk_run low. A request accepted while sleeping raises clk_run from the first entry cycle.
- R7: A return command at a boundary keeps busy high for 2 cycles. It reads the status word from SP and then the program counter from SP+2, and SP ends 4 higher.
- R8: If the restored status word has a nonzero low-power field, clk_run is low once the return completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_boundary | input | 1 | The instruction in progress has completed |
| reti_cmd | input | 1 | Return-from-interrupt command from decode |
| irq_req | input | 1 | Highest-priority pending request present |
| irq_vec_addr | input | DW | Address of the vector word for the pending request |
| irq_ack | output | 1 | Acknowledge pulse to the request source |
| core_upd | input | 1 | Load PC, status and SP from the core (idle only) |
| core_pc | input | DW | Program counter value from the core |
| core_sr | input | DW | Status word value from the core |
| core_sp | input | DW | Stack pointer value from the core |
| pc_out | output | DW | Program counter |
| sr_out | output | DW | Status word |
| sp_out | output | DW | Stack pointer |
| busy | output | 1 | A sequence is running |
| clk_run | output | 1 | Core clock enable |
| mem_addr | output | DW | Word memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe (data returned in the same cycle) |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |

## Verification
Counting from the clock edge that accepts a request as cycle 0, the stack writes appear in cycles 1 and 2 and the acknowledge appears in cycle 3. The cleared status word is visible from cycle 4, and the new program counter and the fall of busy come in cycle 6. A return shows its restored status word, program counter and stack pointer two cycles after the accepting edge. The bench drives inputs and samples outputs on the falling edge. A scoreboard queue holds the expected stack writes and pops one entry on each observed write strobe, and cycle counters taken at the falling edge compare the busy length and the acknowledge position against these fixed figures.

// File: rtl/isq_pkg.sv
package isq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_WAKE,
        S_PUSH_PC,
        S_PUSH_SR,
        S_ACK_CLR,
        S_FETCH_VEC,
        S_LOAD_PC,
        S_POP_SR,
        S_POP_PC
    } isq_state_e;
endpackage

// File: rtl/isq_sp_step.sv
// Stack pointer neighbours: one word below and one word above.
module isq_sp_step #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] sp,
    output logic [DW-1:0] sp_dn,
    output logic [DW-1:0] sp_up
);
    localparam logic [DW-1:0] WORD_STEP = {{(DW-2){1'b0}}, 2'b10};

    always_comb begin
        sp_dn = sp - WORD_STEP;
        sp_up = sp + WORD_STEP;
    end
endmodule

// File: rtl/isq_accept.sv
// Decides whether a return or an interrupt entry starts in this cycle.
module isq_accept (
    input  logic idle,
    input  logic boundary,
    input  logic clk_stopped,
    input  logic irq_req,
    input  logic reti_cmd,
    input  logic gie,
    output logic take_ret,
    output logic take_irq
);
    always_comb begin
        take_ret = idle && boundary && reti_cmd && !clk_stopped;
        take_irq = idle && !take_ret && irq_req && gie
                   && (boundary || clk_stopped);
    end
endmodule

// File: rtl/isq_wake.sv
// Core clock enable: running during any sequence, otherwise set by low-power field.
module isq_wake #(
    parameter int LP_W = 4
) (
    input  logic            busy,
    input  logic [LP_W-1:0] lp_field,
    output logic            clk_run
);
    generate
        if (LP_W == 0) begin : g_no_lp
            assign clk_run = 1'b1;
        end else begin : g_lp
            assign clk_run = busy || (lp_field == '0);
        end
    endgenerate
endmodule

// File: rtl/irq_seq_core.sv
module irq_seq_core #(
    parameter int             DW       = 16,
    parameter int             GIE_BIT  = 3,
    parameter int             LP_LSB   = 4,
    parameter int             LP_W     = 4,
    parameter logic [DW-1:0]  RESET_PC = 16'h0100,
    parameter logic [DW-1:0]  RESET_SP = 16'h0080
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_boundary,
    input  logic          reti_cmd,
    input  logic          irq_req,
    input  logic [DW-1:0] irq_vec_addr,
    output logic          irq_ack,
    input  logic          core_upd,
    input  logic [DW-1:0] core_pc,
    input  logic [DW-1:0] core_sr,
    input  logic [DW-1:0] core_sp,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] sr_out,
    output logic [DW-1:0] sp_out,
    output logic          busy,
    output logic          clk_run,
    output logic [DW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    import isq_pkg::*;

    typedef struct packed {
        isq_state_e    st;
        logic [DW-1:0] pc;
        logic [DW-1:0] sr;
        logic [DW-1:0] sp;
        logic [DW-1:0] vec_addr;
        logic [DW-1:0] vec_word;
    } isq_regs_t;

    isq_regs_t     r_q, r_d;
    logic [DW-1:0] sp_dn, sp_up;
    logic          take_ret, take_irq;
    logic          idle;

    assign idle   = (r_q.st == S_IDLE);
    assign busy   = !idle;
    assign pc_out = r_q.pc;
    assign sr_out = r_q.sr;
    assign sp_out = r_q.sp;

    isq_sp_step #(.DW(DW)) u_sp (
        .sp    (r_q.sp),
        .sp_dn (sp_dn),
        .sp_up (sp_up)
    );

    isq_wake #(.LP_W(LP_W)) u_wake (
        .busy     (busy),
        .lp_field (r_q.sr[LP_LSB +: LP_W]),
        .clk_run  (clk_run)
    );

    isq_accept u_acc (
        .idle        (idle),
        .boundary    (insn_boundary),
        .clk_stopped (!clk_run),
        .irq_req     (irq_req),
        .reti_cmd    (reti_cmd),
        .gie         (r_q.sr[GIE_BIT]),
        .take_ret    (take_ret),
        .take_irq    (take_irq)
    );

    always_comb begin
        r_d       = r_q;
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        irq_ack   = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (take_ret) begin
                    r_d.st = S_POP_SR;
                end else if (take_irq) begin
                    r_d.st = S_WAKE;
                end else if (core_upd) begin
                    r_d.pc = core_pc;
                    r_d.sr = core_sr;
                    r_d.sp = core_sp;
                end
            end
            S_WAKE: begin
                r_d.st = S_PUSH_PC;
            end
            S_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = r_q.pc;
                r_d.sp    = sp_dn;
                r_d.st    = S_PUSH_SR;
            end
            S_PUSH_SR: begin
                mem_we    = 1'b1;
                mem_addr  = sp_dn;
                mem_wdata = r_q.sr;
                r_d.sp    = sp_dn;
                r_d.st    = S_ACK_CLR;
            end
            S_ACK_CLR: begin
                irq_ack      = 1'b1;
                r_d.sr       = '0;
                r_d.vec_addr = irq_vec_addr;
                r_d.st       = S_FETCH_VEC;
            end
            S_FETCH_VEC: begin
                mem_re       = 1'b1;
                mem_addr     = r_q.vec_addr;
                r_d.vec_word = mem_rdata;
                r_d.st       = S_LOAD_PC;
            end
            S_LOAD_PC: begin
                r_d.pc = r_q.vec_word;
                r_d.st = S_IDLE;
            end
            S_POP_SR: begin
                mem_re   = 1'b1;
                mem_addr = r_q.sp;
                r_d.sr   = mem_rdata;
                r_d.sp   = sp_up;
                r_d.st   = S_POP_PC;
            end
            S_POP_PC: begin
                mem_re   = 1'b1;
                mem_addr = r_q.sp;
                r_d.pc   = mem_rdata;
                r_d.sp   = sp_up;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= S_IDLE;
            r_q.pc       <= RESET_PC;
            r_q.sr       <= '0;
            r_q.sp       <= RESET_SP;
            r_q.vec_addr <= '0;
            r_q.vec_word <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          clk_run,
    input logic          irq_ack,
    input logic          mem_we,
    input logic [DW-1:0] sp_out,
    input logic [DW-1:0] sr_out
);
    localparam logic [DW-1:0] TWO = {{(DW-2){1'b0}}, 2'b10};

    // R2: stack writes happen only inside a running sequence
    a_r2_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R3: every stack write lowers SP by one word
    a_r3_push_steps_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp_out == $past(sp_out) - TWO));

    // R4: the acknowledge directly follows the status push
    a_r4_ack_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> $past(mem_we));

    // R4: status word is zero after the acknowledge
    a_r4_sr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (sr_out == '0));

    // R6: a stopped clock only occurs while idle
    a_r6_stop_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |-> !busy);
endmodule

bind irq_seq_core isq_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .clk_run (clk_run),
    .irq_ack (irq_ack),
    .mem_we  (mem_we),
    .sp_out  (sp_out),
    .sr_out  (sr_out)
);

// File: tb/sim_irq_seq_core.sv
`timescale 1ns/1ps
module sim_irq_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        reti_cmd = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] irq_vec_addr = '0;
    logic        irq_ack;
    logic        core_upd = 1'b0;
    logic [15:0] core_pc = '0, core_sr = '0, core_sp = '0;
    logic [15:0] pc_out, sr_out, sp_out;
    logic        busy, clk_run;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re;

    logic [15:0] mem [0:63];
    logic [31:0] exp_q [$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    irq_seq_core u0 (
        .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary), .reti_cmd(reti_cmd),
        .irq_req(irq_req), .irq_vec_addr(irq_vec_addr), .irq_ack(irq_ack),
        .core_upd(core_upd), .core_pc(core_pc), .core_sr(core_sr), .core_sp(core_sp),
        .pc_out(pc_out), .sr_out(sr_out), .sp_out(sp_out), .busy(busy), .clk_run(clk_run),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[6:1]];
    always @(posedge clk) if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: each write strobe pops one expected {addr,data}
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected stack write", {mem_addr, mem_wdata}, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, "R3 stack write order", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic load_core(input logic [15:0] pc, input logic [15:0] sr, input logic [15:0] sp);
        core_pc = pc; core_sr = sr; core_sp = sp; core_upd = 1'b1;
        @(negedge clk);
        core_upd = 1'b0;
    endtask

    task automatic run_entry(input logic [15:0] vec, input logic [15:0] pc0, input logic [15:0] sr0,
                             input logic [15:0] sp0, input logic [15:0] handler, input bit sleeping);
        int n;
        int ack_at;
        exp_q.push_back({sp0 - 16'd2, pc0});
        exp_q.push_back({sp0 - 16'd4, sr0});
        irq_vec_addr = vec;
        irq_req = 1'b1;
        insn_boundary = !sleeping;
        @(negedge clk);
        insn_boundary = 1'b0;
        n = 0; ack_at = -1;
        while (busy && n < 20) begin
            if (irq_ack) begin ack_at = n; irq_req = 1'b0; end
            if (sleeping && n == 0) check(clk_run == 1'b1, "R6 wake in first entry cycle", clk_run, 1);
            n++;
            @(negedge clk);
        end
        irq_req = 1'b0;
        check(n == 6, "R5 entry length", n, 6);
        check(ack_at == 3, "R4 ack position", ack_at, 3);
        check(pc_out == handler, "R5 vector loaded", pc_out, handler);
        check(sr_out == 16'h0, "R4 status cleared", sr_out, 0);
        check(sp_out == sp0 - 16'd4, "R3 sp after entry", sp_out, sp0 - 16'd4);
        check(exp_q.size() == 0, "R3 all pushes seen", exp_q.size(), 0);
    endtask

    task automatic run_return(input logic [15:0] pc1, input logic [15:0] sr1,
                              input logic [15:0] sp1, input bit run1);
        int n;
        reti_cmd = 1'b1; insn_boundary = 1'b1;
        @(negedge clk);
        reti_cmd = 1'b0; insn_boundary = 1'b0;
        n = 0;
        while (busy && n < 20) begin n++; @(negedge clk); end
        check(n == 2, "R7 return length", n, 2);
        check(sr_out == sr1, "R7 status restored", sr_out, sr1);
        check(pc_out == pc1, "R7 pc restored", pc_out, pc1);
        check(sp_out == sp1, "R7 sp restored", sp_out, sp1);
        check(clk_run == run1, "R8 clock after return", clk_run, run1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;
        mem[6'h20] = 16'hABCD;   // vector word at 0x0040
        mem[6'h28] = 16'h5A5A;   // vector word at 0x0050
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(clk_run == 1'b1, "R1 clk_run", clk_run, 1);
        check(pc_out == 16'h0100, "R1 pc", pc_out, 16'h0100);
        check(sp_out == 16'h0080, "R1 sp", sp_out, 16'h0080);
        check(sr_out == 16'h0, "R1 sr", sr_out, 0);

        load_core(16'h1234, 16'h0008, 16'h0070);
        // R2: request without boundary waits
        irq_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(busy == 1'b0, "R2 waits for boundary", busy, 0);
        end
        run_entry(16'h0040, 16'h1234, 16'h0008, 16'h0070, 16'hABCD, 1'b0);

        // R2: global enable now 0, request at boundary ignored
        irq_req = 1'b1; insn_boundary = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(busy == 1'b0, "R2 masked while enable off", busy, 0);
            check(pc_out == 16'hABCD, "R2 pc untouched", pc_out, 16'hABCD);
        end
        irq_req = 1'b0; insn_boundary = 1'b0;

        run_return(16'h1234, 16'h0008, 16'h0070, 1'b1);
        // R2: enable restored, a new request is taken again
        run_entry(16'h0050, 16'h1234, 16'h0008, 16'h0070, 16'h5A5A, 1'b0);
        run_return(16'h1234, 16'h0008, 16'h0070, 1'b1);

        // R6: sleeping core
        load_core(16'h2000, 16'h0018, 16'h0060);
        check(clk_run == 1'b0, "R6 sleep stops clock", clk_run, 0);
        run_entry(16'h0040, 16'h2000, 16'h0018, 16'h0060, 16'hABCD, 1'b1);
        check(clk_run == 1'b1, "R6 running in handler", clk_run, 1);
        run_return(16'h2000, 16'h0018, 16'h0060, 1'b0);
        @(negedge clk);
        check(busy == 1'b0, "R8 stays asleep", busy, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule